// File: doc/BRIEF.md
# SPI Slave Receiver with Overrun Status

This block is the receive side of a serial peripheral port that works as a slave. While the external master holds slave select low, the block samples MOSI on each rising SCK edge and builds words MSB first. Every completed word moves into a small receive FIFO. The local processor pops words through a one-strobe parallel read port. Receiving is full duplex: each time select is asserted, and each time a word completes, the block loads a transmit word. It then shifts that word out on MISO, MSB first, while the next word shifts in.

Status is presented as flags: FIFO full, receive overrun and busy. A word that completes while the FIFO is full is discarded, and the overrun flag is raised. The receive interrupt request has a companion vector-select output, which tells an interrupt controller whether to take the overrun vector or the ordinary data vector. The overrun flag can be cleared only by a two-step sequence: first a status read while the flag is set, then a data read in a later cycle. Hardware reset, software reset, interface-only reset and an active stop-state input each empty the FIFO and clear every flag. SCK, slave select and MOSI each pass through two flip-flops in the system clock domain before edges are detected. The clock mode is idle-low SCK, with data captured on the leading edge.

Top module: `spi_slave_rx`

## Requirements
- R1: While slave select (active low) is asserted, a bit of MOSI is captured on each rising SCK edge, MSB first. After WIDTH bits the word enters the FIFO. A one-cycle dataRd pulse on a non-empty FIFO makes rdData show the oldest stored word from the next cycle on.
- R2: fifoFull is 1 exactly while the FIFO holds DEPTH words. It drops after a data read frees a slot.
- R3: A word that completes while fifoFull is 1 sets overrun to 1.
- R4: A word completed during overrun is not stored. After draining, only the words received before the FIFO filled come out, in arrival order.
- R5: rxIrq is 1 while the FIFO is non-empty or overrun is set. irqVecOvr is 1 (overrun vector) while overrun is set and 0 (data vector) otherwise.
- R6: A data read alone leaves overrun set. overrun clears on a dataRd that follows, in a later cycle, a statusRd made while overrun was 1.
- R7: busy is 1 while slave select is asserted, as seen after synchronization, and 0 otherwise.
- R8: txWord is loaded when select is asserted and again when each word completes. It is driven on MISO MSB first, and advances one bit after each falling SCK edge that follows a captured bit. MISO is 0 while the block is not selected.
- R9: Asynchronous hardware reset (rstN low), and the synchronous inputs swReset, ifReset and stopMode (while high), each empty the FIFO, clear overrun, busy and rxIrq, and set rdData to 0.
- R10: A dataRd on an empty FIFO leaves rdData at its last value and moves no FIFO pointer, so later words still come out in order.
- R11: Deasserting slave select in the middle of a word discards the partial bits. The next word starts from its MSB.
- R12: SCK, slave select and MOSI each pass two flip-flops. After select falls, busy stays 0 at the first clock edge and becomes 1 at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| swReset | input | 1 | Synchronous software reset |
| ifReset | input | 1 | Synchronous reset of this interface only |
| stopMode | input | 1 | Stop state; holds the block cleared while high |
| sckIn | input | 1 | Serial clock from the master |
| csN | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| txWord | input | WIDTH | Word to be shifted out on MISO |
| statusRd | input | 1 | Status-read strobe (first step of the overrun clear) |
| dataRd | input | 1 | Data-read strobe; pops the FIFO |
| rdData | output | WIDTH | Last word popped from the FIFO |
| fifoFull | output | 1 | FIFO holds DEPTH words |
| overrun | output | 1 | Receive overrun flag |
| busy | output | 1 | Slave select asserted |
| rxIrq | output | 1 | Receive interrupt request |
| irqVecOvr | output | 1 | Vector select: 1 overrun, 0 data |

## Verification
The bench builds the block with its default parameters: WIDTH of 8 and DEPTH of 10. With these values an overrun needs eleven back-to-back words, and the bench covers filling, dropping and draining a ten-entry FIFO whose pointers wrap at a length that is not a power of two. The SCK half period is four system clocks, which is long enough for the two-stage synchronizers and for the MISO update after each falling edge to settle before the master samples.

// File: rtl/spirx_pkg.sv
package spirx_pkg;

  typedef struct packed {
    logic sample;   // capture mosi bit into the receive shifter
    logic loadTx;   // load transmit shifter from txWord
    logic shiftTx;  // advance transmit shifter by one bit
    logic push;     // write completed word into FIFO
    logic pop;      // pop oldest word to rdData
    logic clear;    // synchronous clear of all state
  } strobe_t;

endpackage

// File: rtl/spirx_ctrl.sv
module spirx_ctrl
  import spirx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    swReset,
  input  logic    ifReset,
  input  logic    stopMode,
  input  logic    sckIn,
  input  logic    csN,
  input  logic    mosi,
  input  logic    statusRd,
  input  logic    dataRd,
  input  logic    fifoFull,
  input  logic    fifoEmpty,
  output strobe_t stb,
  output logic    mosiBit,
  output logic    csActive,
  output logic    overrun,
  output logic    busy,
  output logic    rxIrq,
  output logic    irqVecOvr
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WIDTH - 1);

  logic       clr;
  logic [1:0] sckPipe;
  logic [1:0] csPipe;
  logic [1:0] mosiPipe;
  logic       sckPrev;
  logic       csPrevAct;
  logic [CNT_W-1:0] bitCnt;
  logic       sckRise;
  logic       sckFall;
  logic       csStart;
  logic       wordDone;
  logic       clrArmed;

  assign clr = swReset | ifReset | stopMode;

  // two-stage synchronizers plus one edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe   <= 2'b00;
      csPipe    <= 2'b11;
      mosiPipe  <= 2'b00;
      sckPrev   <= 1'b0;
      csPrevAct <= 1'b0;
    end else if (clr) begin
      sckPipe   <= 2'b00;
      csPipe    <= 2'b11;
      mosiPipe  <= 2'b00;
      sckPrev   <= 1'b0;
      csPrevAct <= 1'b0;
    end else begin
      sckPipe   <= {sckPipe[0], sckIn};
      csPipe    <= {csPipe[0], csN};
      mosiPipe  <= {mosiPipe[0], mosi};
      sckPrev   <= sckPipe[1];
      csPrevAct <= csActive;
    end
  end

  assign csActive = ~csPipe[1];
  assign mosiBit  = mosiPipe[1];
  assign sckRise  = csActive & sckPipe[1] & ~sckPrev;
  assign sckFall  = csActive & ~sckPipe[1] & sckPrev;
  assign csStart  = csActive & ~csPrevAct;
  assign wordDone = sckRise && (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (clr || !csActive) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      bitCnt <= wordDone ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.clear   = clr;
    stb.sample  = sckRise & ~clr;
    stb.loadTx  = (csStart | wordDone) & ~clr;
    stb.shiftTx = sckFall & (bitCnt != '0) & ~clr;
    stb.push    = wordDone & ~fifoFull & ~clr;
    stb.pop     = dataRd & ~fifoEmpty & ~clr;
  end

  // overrun flag and two-step clear sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun  <= 1'b0;
      clrArmed <= 1'b0;
    end else if (clr) begin
      overrun  <= 1'b0;
      clrArmed <= 1'b0;
    end else begin
      if (dataRd && clrArmed) begin
        overrun  <= 1'b0;
        clrArmed <= 1'b0;
      end else if (statusRd && overrun) begin
        clrArmed <= 1'b1;
      end
      if (wordDone && fifoFull) begin
        overrun <= 1'b1;
      end
    end
  end

  assign busy      = csActive;
  assign rxIrq     = ~fifoEmpty | overrun;
  assign irqVecOvr = overrun;

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && fifoFull && !clr) |=> overrun); // R3

  AST_OVR_ROSE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(fifoFull)); // R3

  AST_OVR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> ($past(dataRd) || $past(clr))); // R6

endmodule

// File: rtl/spirx_datapath.sv
module spirx_datapath
  import spirx_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             mosiBit,
  input  logic             csActive,
  input  logic [WIDTH-1:0] txWord,
  output logic             miso,
  output logic [WIDTH-1:0] rdData,
  output logic             fifoFull,
  output logic             fifoEmpty
);

  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] rxShift;
  logic [WIDTH-1:0] txShift;
  logic [WIDTH-1:0] rxWord;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  assign rxWord = {rxShift[WIDTH-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else if (stb.clear) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (stb.sample) rxShift <= rxWord;
      if (stb.loadTx) txShift <= txWord;
      else if (stb.shiftTx) txShift <= {txShift[WIDTH-2:0], 1'b0};
    end
  end

  assign miso = csActive & txShift[WIDTH-1];

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= rxWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else if (stb.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (stb.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      end
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoFull  = (count == CNT_FULL);
  assign fifoEmpty = (count == '0);

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !fifoFull); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL); // R2

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !fifoEmpty); // R10

endmodule

// File: rtl/spi_slave_rx.sv
module spi_slave_rx
  import spirx_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             ifReset,
  input  logic             stopMode,
  input  logic             sckIn,
  input  logic             csN,
  input  logic             mosi,
  output logic             miso,
  input  logic [WIDTH-1:0] txWord,
  input  logic             statusRd,
  input  logic             dataRd,
  output logic [WIDTH-1:0] rdData,
  output logic             fifoFull,
  output logic             overrun,
  output logic             busy,
  output logic             rxIrq,
  output logic             irqVecOvr
);

  strobe_t stb;
  logic    mosiBit;
  logic    csActive;
  logic    fifoEmpty;

  spirx_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .swReset   (swReset),
    .ifReset   (ifReset),
    .stopMode  (stopMode),
    .sckIn     (sckIn),
    .csN       (csN),
    .mosi      (mosi),
    .statusRd  (statusRd),
    .dataRd    (dataRd),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .stb       (stb),
    .mosiBit   (mosiBit),
    .csActive  (csActive),
    .overrun   (overrun),
    .busy      (busy),
    .rxIrq     (rxIrq),
    .irqVecOvr (irqVecOvr)
  );

  spirx_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .mosiBit   (mosiBit),
    .csActive  (csActive),
    .txWord    (txWord),
    .miso      (miso),
    .rdData    (rdData),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty)
  );

endmodule

// File: tb/tb_spi_slave_rx.sv
module tb_spi_slave_rx;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int DEPTH = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReset = 1'b0, ifReset = 1'b0, stopMode = 1'b0;
  logic sckIn = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic [WIDTH-1:0] txWord = '0;
  logic statusRd = 1'b0, dataRd = 1'b0;
  logic miso, fifoFull, overrun, busy, rxIrq, irqVecOvr;
  logic [WIDTH-1:0] rdData;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit cmpOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_rx #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .ifReset(ifReset),
    .stopMode(stopMode), .sckIn(sckIn), .csN(csN), .mosi(mosi),
    .miso(miso), .txWord(txWord), .statusRd(statusRd), .dataRd(dataRd),
    .rdData(rdData), .fifoFull(fifoFull), .overrun(overrun), .busy(busy),
    .rxIrq(rxIrq), .irqVecOvr(irqVecOvr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, updated on each rising clock
  bit mS1, mS2, mSP, mC1 = 1, mC2 = 1, mCP, mM1, mM2;
  int mBit;
  bit [7:0] mRx, mTx, mRd;
  bit mOvr, mArm;
  byte unsigned q[$];

  always @(posedge clk) begin
    bit act, rise, fall, start, full, done, pop, nOvr, nArm;
    bit [7:0] word;
    if (!rstN || swReset || ifReset || stopMode) begin
      mS1 = 0; mS2 = 0; mSP = 0; mC1 = 1; mC2 = 1; mCP = 0; mM1 = 0; mM2 = 0;
      mBit = 0; mRx = 0; mTx = 0; mRd = 0; mOvr = 0; mArm = 0; q.delete();
    end else begin
      act   = !mC2;
      rise  = act && mS2 && !mSP;
      fall  = act && !mS2 && mSP;
      start = act && !mCP;
      full  = (q.size() == DEPTH);
      done  = rise && (mBit == WIDTH - 1);
      word  = {mRx[6:0], mM2};
      pop   = dataRd && (q.size() != 0);
      if (pop) mRd = q.pop_front();
      if (done && !full) q.push_back(word);
      nOvr = mOvr; nArm = mArm;
      if (dataRd && mArm) begin nOvr = 0; nArm = 0; end
      else if (statusRd && mOvr) nArm = 1;
      if (done && full) nOvr = 1;
      mOvr = nOvr; mArm = nArm;
      if (rise) mRx = word;
      if (!act) mBit = 0;
      else if (rise) mBit = done ? 0 : mBit + 1;
      if (start || done) mTx = txWord;
      else if (fall && mBit != 0) mTx = mTx << 1;
      mSP = mS2; mS2 = mS1; mS1 = sckIn;
      mCP = act; mC2 = mC1; mC1 = csN;
      mM2 = mM1; mM1 = mosi;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R2 fifoFull", fifoFull, q.size() == DEPTH);
      chk("R3 overrun", overrun, mOvr);
      chk("R1 rdData", rdData, mRd);
      chk("R7 busy", busy, !mC2);
      chk("R5 rxIrq", rxIrq, (q.size() != 0) || mOvr);
      chk("R5 irqVecOvr", irqVecOvr, mOvr);
      chk("R8 miso", miso, (!mC2) && mTx[7]);
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL R1 watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] d, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i];
      tick(HALF);
      got[i] = miso;
      sckIn = 1'b1;
      tick(HALF);
      sckIn = 1'b0;
    end
  endtask

  task automatic sendWord(input logic [7:0] d, output logic [7:0] got);
    sendBits(d, 8, got);
  endtask

  task automatic selectOn();
    csN = 1'b0;
    tick(6);
  endtask

  task automatic selectOff();
    tick(6);
    csN = 1'b1;
    tick(6);
  endtask

  task automatic readData();
    dataRd = 1'b1;
    tick(1);
    dataRd = 1'b0;
    tick(1);
  endtask

  task automatic readStatus();
    statusRd = 1'b1;
    tick(1);
    statusRd = 1'b0;
    tick(1);
  endtask

  initial begin
    logic [7:0] got;
    tick(3);
    rstN = 1'b1;
    tick(2);
    cmpOn = 1'b1;
    // R9 reset state
    chk("R9 reset fifoFull", fifoFull, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset rxIrq", rxIrq, 0);
    chk("R9 reset rdData", rdData, 0);

    // R12 synchronizer latency on select
    txWord = 8'hA5;
    csN = 1'b0;
    tick(1);
    chk("R12 busy first edge", busy, 0);
    tick(1);
    chk("R12 busy second edge", busy, 1);
    tick(4);
    chk("R7 busy while selected", busy, 1);
    txWord = 8'h96;
    sendWord(8'h3C, got);
    chk("R8 first tx word", got, 8'hA5);
    sendWord(8'h81, got);
    chk("R8 second tx word", got, 8'h96);
    selectOff();
    chk("R7 busy after deselect", busy, 0);
    chk("R8 miso idle", miso, 0);
    chk("R5 irq with data", rxIrq, 1);
    readData();
    chk("R1 first word", rdData, 8'h3C);
    readData();
    chk("R1 second word", rdData, 8'h81);
    chk("R5 irq drained", rxIrq, 0);

    // R10 empty read
    readData();
    chk("R10 empty read keeps value", rdData, 8'h81);
    selectOn();
    sendWord(8'h42, got);
    selectOff();
    readData();
    chk("R10 pointers intact", rdData, 8'h42);

    // R2 fill, R3 overrun, R4 drop, R6 clear sequence
    selectOn();
    for (int i = 0; i < DEPTH; i++) sendWord(8'h10 + 8'(i), got);
    tick(6);
    chk("R2 full after DEPTH words", fifoFull, 1);
    chk("R5 data vector", irqVecOvr, 0);
    sendWord(8'hEE, got);
    tick(6);
    chk("R3 overrun set", overrun, 1);
    chk("R5 overrun vector", irqVecOvr, 1);
    readData();
    chk("R6 data read alone keeps overrun", overrun, 1);
    chk("R2 full cleared by read", fifoFull, 0);
    chk("R4 oldest word", rdData, 8'h10);
    readStatus();
    chk("R6 status read alone keeps overrun", overrun, 1);
    readData();
    chk("R6 overrun cleared", overrun, 0);
    chk("R4 second word", rdData, 8'h11);
    for (int i = 2; i < DEPTH; i++) begin
      readData();
      chk("R4 drain order", rdData, 8'h10 + i);
    end
    chk("R4 dropped word absent", rxIrq, 0);
    readData();
    chk("R4 no extra word", rdData, 8'h19);
    selectOff();

    // R11 partial word discarded
    selectOn();
    sendBits(8'hFF, 3, got);
    selectOff();
    selectOn();
    sendWord(8'h5A, got);
    selectOff();
    readData();
    chk("R11 partial discarded", rdData, 8'h5A);

    // R9 stop state
    selectOn();
    sendWord(8'h01, got);
    sendWord(8'h02, got);
    tick(4);
    stopMode = 1'b1;
    tick(3);
    chk("R9 stop busy", busy, 0);
    chk("R9 stop rxIrq", rxIrq, 0);
    chk("R9 stop rdData", rdData, 0);
    stopMode = 1'b0;
    selectOff();

    // R9 software reset clears overrun
    selectOn();
    for (int i = 0; i <= DEPTH; i++) sendWord(8'h30 + 8'(i), got);
    tick(6);
    chk("R3 overrun before reset", overrun, 1);
    swReset = 1'b1;
    tick(1);
    swReset = 1'b0;
    tick(1);
    chk("R9 swReset overrun", overrun, 0);
    chk("R9 swReset full", fifoFull, 0);
    selectOff();

    // R9 interface reset
    selectOn();
    sendWord(8'h77, got);
    tick(4);
    ifReset = 1'b1;
    tick(1);
    ifReset = 1'b0;
    tick(1);
    chk("R9 ifReset rxIrq", rxIrq, 0);
    selectOff();
    chk("R9 ifReset empty", rxIrq, 0);

    tick(4);
    finish_run();
  end

endmodule